// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This block carries out the six control and status register access instructions of a 64-bit integer core. Each request arrives already split into a 3-bit function code, a 12-bit register address, a 64-bit source operand and a 5-bit immediate. The unit returns the register's old contents for the destination register in the same cycle. It also computes the updated value, which is a plain replacement, an OR with a mask, or an AND with the inverted mask. The update is committed on the next rising clock edge.

The mask is the source operand or the zero-extended immediate. Function codes 1 to 3 select the register-source operations and 5 to 7 select the immediate operations. For set and clear, a zero mask cancels the write altogether. Function code 0 is not a register access. It reports an environment-call fault for address 0x000 and a breakpoint fault for address 0x001. A small parameterised bank of registers, placed at consecutive addresses from a base, stands in for the register space. Any other address is reported as illegal.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset, every implemented register reads as zero. This also holds after a reset applied in the middle of operation.
- R2: For an access (func_code 1, 2, 3, 5, 6 or 7) to an implemented address, rd_value shows the register's pre-update contents combinationally in the request cycle.
- R3: The write forms (func_code 1 and 5) always assert wr_en, even with a zero operand, and new_value equals the mask. new_value is zero whenever wr_en is low.
- R4: The set forms (func_code 2 and 6) with a non-zero mask write old OR mask.
- R5: The clear forms (func_code 3 and 7) with a non-zero mask write old AND NOT mask.
- R6: Set or clear with a zero mask, from the register source or the immediate, leaves wr_en low and the register unchanged.
- R7: For func_code 5, 6 and 7, the mask is imm_field zero-extended to 64 bits, so bits 63:5 of the mask are zero.
- R8: An access to an address outside base..base+NUM_CSR-1 (base 0x340, four registers by default) raises illegal, returns zero on rd_value and does not write.
- R9: func_code 0 with address 0x000 raises fault_ecall, and with 0x001 raises fault_break. Neither writes. func_code 0 with any other address, and func_code 4, raise illegal. At most one of illegal, fault_ecall and fault_break is high.
- R10: With req_valid low, wr_en, illegal and both fault outputs are low and no register changes.
- R11: A value written on a clock edge is returned on rd_value by the next access to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is present this cycle |
| func_code | input | 3 | Instruction function field selecting the operation |
| csr_addr | input | 12 | Register address field |
| src_value | input | 64 | Source register operand |
| imm_field | input | 5 | Immediate mask for the immediate forms |
| rd_value | output | 64 | Old register value for the destination register |
| wr_en | output | 1 | High when the register is written on this edge |
| new_value | output | 64 | Value written when wr_en is high, zero otherwise |
| illegal | output | 1 | Bad function code or unimplemented address |
| fault_ecall | output | 1 | Environment-call fault |
| fault_break | output | 1 | Breakpoint fault |

## Verification
A wrong register value stays hidden until the next access to that address. At that point rd_value is wrong in the same cycle. A wrongly suppressed or spurious write shows on wr_en at once, and a wrong value shows on new_value at once. For this reason the bench follows every kind of update with a read of the same address on the very next cycle. The reference model is compared on every request, so a corrupted register is flagged no later than its next access.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  typedef enum logic [1:0] {
    CSR_OP_NONE  = 2'd0,
    CSR_OP_WRITE = 2'd1,
    CSR_OP_SET   = 2'd2,
    CSR_OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [2:0] FN_SYSTEM = 3'd0;
  localparam logic [2:0] FN_RSVD   = 3'd4;

endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
  import csr_rmw_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 12,
  parameter int IMM_W  = 5
) (
  input  logic              valid_i,
  input  logic [2:0]        func_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [IMM_W-1:0]  imm_i,
  output csr_op_e           op_o,
  output logic [XLEN-1:0]   mask_o,
  output logic              access_o,
  output logic              ecall_o,
  output logic              brk_o,
  output logic              bad_func_o
);

  localparam logic [ADDR_W-1:0] ADDR_ECALL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_BRK   = ADDR_W'(1);

  always_comb begin
    op_o       = CSR_OP_NONE;
    mask_o     = '0;
    access_o   = 1'b0;
    ecall_o    = 1'b0;
    brk_o      = 1'b0;
    bad_func_o = 1'b0;
    if (valid_i) begin
      if (func_i == FN_SYSTEM) begin
        if (addr_i == ADDR_ECALL)      ecall_o    = 1'b1;
        else if (addr_i == ADDR_BRK)   brk_o      = 1'b1;
        else                           bad_func_o = 1'b1;
      end else if (func_i == FN_RSVD) begin
        bad_func_o = 1'b1;
      end else begin
        access_o = 1'b1;
        mask_o   = func_i[2] ? {{(XLEN-IMM_W){1'b0}}, imm_i} : src_i;
        unique case (func_i[1:0])
          2'b01:   op_o = CSR_OP_WRITE;
          2'b10:   op_o = CSR_OP_SET;
          2'b11:   op_o = CSR_OP_CLEAR;
          default: op_o = CSR_OP_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/csr_update.sv
module csr_update
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  csr_op_e         op_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] mask_i,
  output logic [XLEN-1:0] new_o,
  output logic            want_wr_o
);

  logic mask_nz;
  assign mask_nz = |mask_i;

  always_comb begin
    new_o     = old_i;
    want_wr_o = 1'b0;
    unique case (op_i)
      CSR_OP_WRITE: begin new_o = mask_i;           want_wr_o = 1'b1;    end
      CSR_OP_SET:   begin new_o = old_i | mask_i;   want_wr_o = mask_nz; end
      CSR_OP_CLEAR: begin new_o = old_i & ~mask_i;  want_wr_o = mask_nz; end
      default:      begin new_o = old_i;            want_wr_o = 1'b0;    end
    endcase
  end

endmodule

// File: rtl/csr_file.sv
module csr_file #(
  parameter int XLEN      = 64,
  parameter int ADDR_W    = 12,
  parameter int NUM_CSR   = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h340
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic              hit_o,
  output logic [XLEN-1:0]   rdata_o
);

  logic [NUM_CSR-1:0] hit_vec;
  logic [XLEN-1:0]    q_arr [NUM_CSR];

  for (genvar gi = 0; gi < NUM_CSR; gi++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = BASE_ADDR + ADDR_W'(gi);
    logic            en;
    logic [XLEN-1:0] d;

    assign hit_vec[gi] = (addr_i == MY_ADDR);

    always_comb begin
      en = we_i && hit_vec[gi];
      d  = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_arr[gi] <= '0;
      else if (en) q_arr[gi] <= d;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CSR; i++) begin
      if (hit_vec[i]) rdata_o = rdata_o | q_arr[i];
    end
  end

  assign hit_o = |hit_vec;

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int ADDR_W  = 12,
  parameter int IMM_W   = 5,
  parameter int NUM_CSR = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h340
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        func_code,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   src_value,
  input  logic [IMM_W-1:0]  imm_field,
  output logic [XLEN-1:0]   rd_value,
  output logic              wr_en,
  output logic [XLEN-1:0]   new_value,
  output logic              illegal,
  output logic              fault_ecall,
  output logic              fault_break
);

  logic rst_q1, rst_q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  csr_op_e         op;
  logic [XLEN-1:0] mask;
  logic            access, bad_func, hit, want_wr;
  logic [XLEN-1:0] old_val, upd_val;

  csr_op_decode #(.XLEN(XLEN), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_dec (
    .valid_i    (req_valid),
    .func_i     (func_code),
    .addr_i     (csr_addr),
    .src_i      (src_value),
    .imm_i      (imm_field),
    .op_o       (op),
    .mask_o     (mask),
    .access_o   (access),
    .ecall_o    (fault_ecall),
    .brk_o      (fault_break),
    .bad_func_o (bad_func)
  );

  csr_update #(.XLEN(XLEN)) u_upd (
    .op_i      (op),
    .old_i     (old_val),
    .mask_i    (mask),
    .new_o     (upd_val),
    .want_wr_o (want_wr)
  );

  csr_file #(
    .XLEN(XLEN), .ADDR_W(ADDR_W), .NUM_CSR(NUM_CSR), .BASE_ADDR(BASE_ADDR)
  ) u_file (
    .clk     (clk),
    .rst_n   (rst_q2),
    .addr_i  (csr_addr),
    .we_i    (wr_en),
    .wdata_i (upd_val),
    .hit_o   (hit),
    .rdata_o (old_val)
  );

  always_comb begin
    wr_en     = access && hit && want_wr && rst_q2;
    illegal   = bad_func || (access && !hit);
    rd_value  = (access && hit) ? old_val : '0;
    new_value = wr_en ? upd_val : '0;
  end

endmodule

// File: rtl/csr_rmw_checker.sv
module csr_rmw_checker #(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 12,
  parameter int IMM_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        func_code,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [XLEN-1:0]   src_value,
  input logic [IMM_W-1:0]  imm_field,
  input logic [XLEN-1:0]   rd_value,
  input logic              wr_en,
  input logic [XLEN-1:0]   new_value,
  input logic              illegal,
  input logic              fault_ecall,
  input logic              fault_break
);

  logic is_access;
  assign is_access = (func_code != 3'd0) && (func_code != 3'd4);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(wr_en || illegal || fault_ecall || fault_break)); // R10

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, fault_ecall, fault_break})); // R9

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ecall || fault_break) |-> !wr_en); // R9

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wr_en && rd_value == '0)); // R8

  AST_REG_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (func_code == 3'd2 || func_code == 3'd3) && src_value == '0) |-> !wr_en); // R6

  AST_IMM_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (func_code == 3'd6 || func_code == 3'd7) && imm_field == '0) |-> !wr_en); // R6

  AST_IMM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && func_code == 3'd5) |-> (new_value[XLEN-1:IMM_W] == '0)); // R7

  AST_NO_WRITE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (new_value == '0)); // R3

  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!(req_valid && is_access && csr_addr == $past(csr_addr))
               || rd_value == $past(new_value))); // R11

endmodule

bind csr_rmw_unit csr_rmw_checker #(.XLEN(XLEN), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .func_code(func_code),
  .csr_addr(csr_addr), .src_value(src_value), .imm_field(imm_field),
  .rd_value(rd_value), .wr_en(wr_en), .new_value(new_value),
  .illegal(illegal), .fault_ecall(fault_ecall), .fault_break(fault_break)
);

// File: tb/csr_rmw_unit_tb.sv
module csr_rmw_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  func_code;
  logic [11:0] csr_addr;
  logic [63:0] src_value;
  logic [4:0]  imm_field;
  logic [63:0] rd_value;
  logic        wr_en;
  logic [63:0] new_value;
  logic        illegal, fault_ecall, fault_break;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] model [4];

  always #4 clk = ~clk;

  csr_rmw_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .func_code(func_code),
    .csr_addr(csr_addr), .src_value(src_value), .imm_field(imm_field),
    .rd_value(rd_value), .wr_en(wr_en), .new_value(new_value),
    .illegal(illegal), .fault_ecall(fault_ecall), .fault_break(fault_break)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) model[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    func_code = '0; csr_addr = '0; src_value = '0; imm_field = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_op(input bit v, input logic [2:0] f, input logic [11:0] a,
                        input logic [63:0] s, input logic [4:0] im, input string tag);
    logic [63:0] e_rd, e_nv, mask, old;
    logic e_we, e_ill, e_ec, e_bk, imp;
    int idx;
    @(negedge clk);
    req_valid = v; func_code = f; csr_addr = a; src_value = s; imm_field = im;
    #2;
    e_rd = '0; e_nv = '0; e_we = 0; e_ill = 0; e_ec = 0; e_bk = 0;
    imp = (a >= 12'h340) && (a <= 12'h343);
    idx = int'(a - 12'h340);
    if (v) begin
      if (f == 3'd0) begin
        if (a == 12'h000)      e_ec = 1;
        else if (a == 12'h001) e_bk = 1;
        else                   e_ill = 1;
      end else if (f == 3'd4) begin
        e_ill = 1;
      end else if (!imp) begin
        e_ill = 1;
      end else begin
        old  = model[idx];
        e_rd = old;
        mask = (f >= 3'd5) ? {59'd0, im} : s;
        case (f & 3'd3)
          3'd1:    begin e_we = 1;          e_nv = mask;         end
          3'd2:    begin e_we = (mask != 0); e_nv = old | mask;  end
          default: begin e_we = (mask != 0); e_nv = old & ~mask; end
        endcase
        if (!e_we) e_nv = '0;
      end
    end
    chk(tag, "rd_value", rd_value, e_rd);
    chk(tag, "wr_en", {63'd0, wr_en}, {63'd0, e_we});
    chk(tag, "new_value", new_value, e_nv);
    chk(tag, "illegal", {63'd0, illegal}, {63'd0, e_ill});
    chk(tag, "fault_ecall", {63'd0, fault_ecall}, {63'd0, e_ec});
    chk(tag, "fault_break", {63'd0, fault_break}, {63'd0, e_bk});
    if (e_we) model[idx] = e_nv;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1: every register starts at zero (zero-mask set reads without writing)
    for (int i = 0; i < 4; i++) run_op(1, 3'd2, 12'h340 + 12'(i), 64'd0, 5'd0, "R1");
    // R3 / R11: register-source write then readback
    run_op(1, 3'd1, 12'h340, 64'hDEAD_BEEF_0123_4567, 5'd0, "R3");
    run_op(1, 3'd2, 12'h340, 64'd0, 5'd0, "R11");
    run_op(1, 3'd1, 12'h341, 64'd0, 5'd0, "R3");
    run_op(1, 3'd1, 12'h343, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, "R3");
    run_op(1, 3'd3, 12'h343, 64'd0, 5'd0, "R2");
    // R4 set forms
    run_op(1, 3'd2, 12'h342, 64'h0000_00F0_0000_0001, 5'd0, "R4");
    run_op(1, 3'd6, 12'h342, 64'd0, 5'h0A, "R4");
    run_op(1, 3'd6, 12'h342, 64'd0, 5'd0, "R11");
    // R5 clear forms
    run_op(1, 3'd3, 12'h340, 64'hFFFF_0000_0000_0000, 5'd0, "R5");
    run_op(1, 3'd7, 12'h340, 64'd0, 5'h07, "R5");
    run_op(1, 3'd2, 12'h340, 64'd0, 5'd0, "R11");
    // R6 zero masks keep contents
    run_op(1, 3'd3, 12'h343, 64'd0, 5'h1F, "R6");
    run_op(1, 3'd7, 12'h343, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, "R6");
    run_op(1, 3'd6, 12'h343, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, "R6");
    run_op(1, 3'd2, 12'h343, 64'd0, 5'd0, "R6");
    // R7 immediate zero-extension ignores the register operand
    run_op(1, 3'd5, 12'h341, 64'hAAAA_AAAA_AAAA_AAAA, 5'h1F, "R7");
    run_op(1, 3'd5, 12'h341, 64'd0, 5'd0, "R3");
    run_op(1, 3'd2, 12'h341, 64'd0, 5'd0, "R7");
    // R8 unimplemented addresses
    run_op(1, 3'd1, 12'h344, 64'h1234, 5'd0, "R8");
    run_op(1, 3'd2, 12'h33F, 64'h1, 5'd0, "R8");
    run_op(1, 3'd5, 12'hFFF, 64'd0, 5'h3, "R8");
    // R9 function code 0 and 4
    run_op(1, 3'd0, 12'h000, 64'd0, 5'd0, "R9");
    run_op(1, 3'd0, 12'h001, 64'd0, 5'd0, "R9");
    run_op(1, 3'd0, 12'h340, 64'd5, 5'd0, "R9");
    run_op(1, 3'd4, 12'h340, 64'd5, 5'd1, "R9");
    run_op(1, 3'd2, 12'h340, 64'd0, 5'd0, "R9");
    // R10 invalid request with a write pattern leaves register untouched
    run_op(0, 3'd1, 12'h342, 64'h5555, 5'd0, "R10");
    run_op(1, 3'd2, 12'h342, 64'd0, 5'd0, "R10");
    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [11:0] a;
      logic [63:0] s;
      int sel = $urandom_range(0, 7);
      a = (sel < 4) ? 12'h340 + 12'(sel) : (sel == 4) ? 12'h344 : (sel == 5) ? 12'h000 : (sel == 6) ? 12'h001 : 12'h341;
      s = ($urandom_range(0, 3) == 0) ? 64'd0 : {$urandom(), $urandom()};
      run_op($urandom_range(0, 9) != 0, 3'($urandom_range(0, 7)), a, s, 5'($urandom_range(0, 31)), "R2");
    end
    // R1 reset in the middle of operation
    run_op(1, 3'd1, 12'h342, 64'h77, 5'd0, "R3");
    do_reset();
    for (int i = 0; i < 4; i++) run_op(1, 3'd3, 12'h340 + 12'(i), 64'd0, 5'd0, "R1");
    @(negedge clk);
    req_valid = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule